// File: doc/BRIEF.md
# ADC Conversion Sequencer Controller

This block is the digital control core of a 10-bit successive-approximation converter. Software programs two 16-bit control words through a simple write port. The block then turns trigger events into a sampling window and a conversion request for an external analog converter. It walks through one channel or a descending run of channels, and formats each returned 10-bit code into a 16-bit result word. It also raises a busy indication and an interrupt flag.

The sampling window is timed in ticks of a divided conversion clock. A trigger comes from a self-clearing software start bit or from one of three timer lines, and its polarity can be inverted. Four sequence modes are available: single channel once, channel run once, single channel repeated, and channel run repeated. A chaining option lets one trigger edge drive every later conversion. Configuration fields are locked while conversions are enabled. The reference-select field is only stored.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset both control read-back words, `result_o`, `busy_o`, `irq_flag_o`, `irq_o`, `sample_o` and `convert_o` are all 0.
- R2: Control word A bits are: [0] start, [1] enable, [2] flag, [3] interrupt enable, [5:4] hold length, [6] chaining, [9:7] reference select. Control word B bits are: [1:0] mode, [2] format, [3] invert, [5:4] trigger source, [8:6] divider, [12:9] channel. All of word B, and word A bits [9:4], take a write only while the enable bit already stored is 0. Writes to them at other times leave the read-back value unchanged.
- R3: `sample_o` stays high for exactly L*(D+1) clock cycles. L is 4, 8, 16 or 64 for hold-length codes 0 to 3. D is the divider field value, 0 to 7.
- R4: Trigger source code 0 selects the software start, and codes 1 to 3 select `timer_trig[0..2]`. When invert is 1 the selected line is complemented. A conversion begins only on a rising edge of the resulting signal while enable is 1. Edges on unselected lines, and edges while disabled, start nothing.
- R5: The start bit always reads back as 0. A single write that sets both start and enable begins a conversion. A start written together with enable 0 is ignored.
- R6: Mode 0 converts the programmed channel once, then returns to idle.
- R7: Mode 1 converts the programmed channel, then each lower channel down to channel 0, then returns to idle.
- R8: Mode 2 repeats the programmed channel. Mode 3 repeats the descending run, restarting at the programmed channel after channel 0.
- R9: With chaining 0, every conversion after the first needs a new trigger edge, and `busy_o` stays 1 while the block waits for it. With chaining 1, the next sample starts as soon as a result is loaded.
- R10: If enable is 0 when a conversion completes, its result is still loaded and the block returns to idle with no further conversion.
- R11: With format 0 the result is the code right-justified, with bits 15:10 zero. With format 1 it is the code left-justified with its MSB inverted (two's complement of an offset code), with bits 5:0 zero.
- R12: `irq_flag_o` sets in the cycle after a result is loaded. It clears on `irq_ack` or on a word-A write with bit 2 at 0. A load wins over a clear. `irq_o` equals flag AND interrupt enable.
- R13: `busy_o` is 1 from the cycle after an accepted trigger until the last result of the sequence has been loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control write strobe |
| wr_sel | input | 1 | 0 selects control word A, 1 selects word B |
| wr_data | input | 16 | Control write data |
| ctrl_a_q | output | 16 | Read-back of word A (start reads 0) |
| ctrl_b_q | output | 16 | Read-back of word B |
| timer_trig | input | 3 | Timer trigger lines |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| sample_o | output | 1 | Sample-and-hold window to the analog model |
| convert_o | output | 1 | Conversion request, held until done |
| chan_o | output | 4 | Channel being sampled or converted |
| conv_done_i | input | 1 | One-cycle conversion-complete pulse |
| conv_data_i | input | 10 | Converted code, valid with conv_done_i |
| result_o | output | 16 | Formatted result register |
| busy_o | output | 1 | Sequence, sample or conversion active |
| irq_flag_o | output | 1 | Interrupt flag |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check these invariants:
- sampling and conversion only occur while busy,
- a sample window opens only after enable was set,
- the flag follows each load,
- each loaded result has the zero bits its format requires,
- word B holds while it is locked,
- the block goes idle after a single-mode result or after a completion with enable cleared,
- the channel does not move in repeat-single mode.

The bench scenarios are needed for the rest: the exact window length over every hold/divider pair, the channel order of each sequence mode including the wrap, trigger source selection and inversion, and the wait for a new edge when chaining is off.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int REG_W   = 16;
  localparam int DATA_W  = 10;
  localparam int CHAN_W  = 4;
  localparam int DIV_W   = 3;
  localparam int NTIMER  = 3;
  localparam int SHT_MAX = 64;
  localparam int TICK_W  = $clog2(SHT_MAX);
  localparam int PAD_W   = REG_W - DATA_W;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SAMPLE, ST_CONV} seq_state_t;
  typedef enum logic [1:0] {MD_SINGLE = 2'd0, MD_SEQ = 2'd1, MD_RPT_ONE = 2'd2, MD_RPT_SEQ = 2'd3} seq_mode_t;

  typedef struct packed {
    logic [CHAN_W-1:0] chan;
    logic [DIV_W-1:0]  div;
    logic [1:0]        src;
    logic              inv;
    logic              fmt;
    logic [1:0]        mode;
    logic              msc;
    logic [1:0]        sht;
    logic [2:0]        refsel;
  } seq_cfg_t;

  // hold length in divided-clock ticks
  function automatic int unsigned sht_ticks(input logic [1:0] code);
    case (code)
      2'd0:    return 4;
      2'd1:    return 8;
      2'd2:    return 16;
      default: return SHT_MAX;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] fmt_result(input logic [DATA_W-1:0] d, input logic tc);
    if (tc) return {~d[DATA_W-1], d[DATA_W-2:0], {PAD_W{1'b0}}};
    return {{PAD_W{1'b0}}, d};
  endfunction
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             res_load,
  input  logic             irq_ack,
  output seq_cfg_t         cfg,
  output logic             en,
  output logic             ie,
  output logic             flag,
  output logic             sw_start,
  output logic [REG_W-1:0] ctrl_a_q,
  output logic [REG_W-1:0] ctrl_b_q
);
  logic wr_a, wr_b;
  logic unused_bits;

  assign wr_a = wr_en && !wr_sel;
  assign wr_b = wr_en &&  wr_sel;
  assign unused_bits = ^{wr_data[15:13], wr_data[12:10]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '0;
      en       <= 1'b0;
      ie       <= 1'b0;
      flag     <= 1'b0;
      sw_start <= 1'b0;
    end else begin
      sw_start <= wr_a && wr_data[0] && wr_data[1];
      if (wr_a) begin
        en <= wr_data[1];
        ie <= wr_data[3];
        if (!en) begin
          cfg.refsel <= wr_data[9:7];
          cfg.msc    <= wr_data[6];
          cfg.sht    <= wr_data[5:4];
        end
      end
      if (wr_b && !en) begin
        cfg.chan <= wr_data[12:9];
        cfg.div  <= wr_data[8:6];
        cfg.src  <= wr_data[5:4];
        cfg.inv  <= wr_data[3];
        cfg.fmt  <= wr_data[2];
        cfg.mode <= wr_data[1:0];
      end
      if (res_load)     flag <= 1'b1;
      else if (irq_ack) flag <= 1'b0;
      else if (wr_a)    flag <= wr_data[2];
    end
  end

  assign ctrl_a_q = {6'b0, cfg.refsel, cfg.msc, cfg.sht, ie, flag, en, 1'b0};
  assign ctrl_b_q = {3'b0, cfg.chan, cfg.div, cfg.src, cfg.inv, cfg.fmt, cfg.mode};
endmodule

// File: rtl/adc_seq_trig.sv
module adc_seq_trig
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        src,
  input  logic              inv,
  input  logic              sw_start,
  input  logic [NTIMER-1:0] timer_trig,
  output logic              trig_edge
);
  logic raw, lvl, lvl_q;

  always_comb begin
    case (src)
      2'd0:    raw = sw_start;
      2'd1:    raw = timer_trig[0];
      2'd2:    raw = timer_trig[1];
      default: raw = timer_trig[2];
    endcase
  end

  assign lvl = raw ^ inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign trig_edge = lvl && !lvl_q;
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] div,
  input  logic [1:0]       sht,
  output logic             done
);
  logic [DIV_W-1:0]  div_cnt;
  logic [TICK_W-1:0] tick_cnt;
  logic [TICK_W-1:0] last_tick;
  logic              run;
  logic              tick;

  assign last_tick = TICK_W'(sht_ticks(sht) - 32'd1);
  assign tick      = run && (div_cnt == div);
  assign done      = tick && (tick_cnt == last_tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      div_cnt  <= '0;
      tick_cnt <= '0;
    end else if (start) begin
      run      <= 1'b1;
      div_cnt  <= '0;
      tick_cnt <= '0;
    end else if (run) begin
      if (done) begin
        run <= 1'b0;
      end else if (tick) begin
        div_cnt  <= '0;
        tick_cnt <= tick_cnt + TICK_W'(1);
      end else begin
        div_cnt <= div_cnt + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  seq_cfg_t          cfg,
  input  logic              en,
  input  logic              trig_edge,
  input  logic              tmr_done,
  input  logic              conv_done,
  output logic [CHAN_W-1:0] chan,
  output logic              tmr_start,
  output logic              res_load,
  output logic              sample,
  output logic              convert,
  output logic              busy
);
  seq_state_t        state, state_nxt;
  logic [CHAN_W-1:0] chan_nxt;
  logic              go_on;

  always_comb begin
    state_nxt = state;
    chan_nxt  = chan;
    tmr_start = 1'b0;
    res_load  = 1'b0;
    go_on     = 1'b0;
    case (state)
      ST_IDLE: if (en && trig_edge) begin
        state_nxt = ST_SAMPLE;
        chan_nxt  = cfg.chan;
        tmr_start = 1'b1;
      end
      ST_WAIT: if (!en) begin
        state_nxt = ST_IDLE;
      end else if (trig_edge) begin
        state_nxt = ST_SAMPLE;
        tmr_start = 1'b1;
      end
      ST_SAMPLE: if (tmr_done) state_nxt = ST_CONV;
      default: if (conv_done) begin
        res_load  = 1'b1;
        state_nxt = ST_IDLE;
        case (seq_mode_t'(cfg.mode))
          MD_SINGLE:  go_on = 1'b0;
          MD_SEQ: begin
            go_on    = (chan != '0);
            chan_nxt = chan - CHAN_W'(1);
          end
          MD_RPT_ONE: go_on = 1'b1;
          default: begin
            go_on    = 1'b1;
            chan_nxt = (chan == '0) ? cfg.chan : chan - CHAN_W'(1);
          end
        endcase
        if (!go_on) begin
          chan_nxt = chan;
        end else if (en) begin
          state_nxt = cfg.msc ? ST_SAMPLE : ST_WAIT;
          tmr_start = cfg.msc;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      chan  <= '0;
    end else begin
      state <= state_nxt;
      chan  <= chan_nxt;
    end
  end

  assign sample  = (state == ST_SAMPLE);
  assign convert = (state == ST_CONV);
  assign busy    = (state != ST_IDLE);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  ctrl_a_q,
  output logic [REG_W-1:0]  ctrl_b_q,
  input  logic [NTIMER-1:0] timer_trig,
  input  logic              irq_ack,
  output logic              sample_o,
  output logic              convert_o,
  output logic [CHAN_W-1:0] chan_o,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic [REG_W-1:0]  result_o,
  output logic              busy_o,
  output logic              irq_flag_o,
  output logic              irq_o
);
  seq_cfg_t cfg;
  logic     en, ie, flag, sw_start;
  logic     trig_edge, tmr_start, tmr_done, res_load;

  adc_seq_regs u_regs (
    .clk, .rst_n, .wr_en, .wr_sel, .wr_data,
    .res_load, .irq_ack,
    .cfg, .en, .ie, .flag, .sw_start,
    .ctrl_a_q, .ctrl_b_q
  );

  adc_seq_trig u_trig (
    .clk, .rst_n, .src(cfg.src), .inv(cfg.inv),
    .sw_start, .timer_trig, .trig_edge
  );

  adc_seq_timer u_timer (
    .clk, .rst_n, .start(tmr_start), .div(cfg.div), .sht(cfg.sht), .done(tmr_done)
  );

  adc_seq_fsm u_fsm (
    .clk, .rst_n, .cfg, .en, .trig_edge, .tmr_done,
    .conv_done(conv_done_i), .chan(chan_o), .tmr_start, .res_load,
    .sample(sample_o), .convert(convert_o), .busy(busy_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        result_o <= '0;
    else if (res_load) result_o <= fmt_result(conv_data_i, cfg.fmt);
  end

  assign irq_flag_o = flag;
  assign irq_o      = flag && ie;
endmodule

// File: rtl/adc_seq_checks.sv
module adc_seq_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        sample_o,
  input logic        convert_o,
  input logic        busy_o,
  input logic        irq_flag_o,
  input logic [15:0] result_o,
  input logic        res_load,
  input logic        en,
  input logic        cfg_fmt,
  input logic [1:0]  cfg_mode,
  input logic        conv_done_i,
  input logic        wr_en,
  input logic        wr_sel,
  input logic [15:0] ctrl_b_q,
  input logic [3:0]  chan_o
);
  a_r13_sample_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> busy_o);
  a_r13_convert_busy: assert property (@(posedge clk) disable iff (!rst_n)
    convert_o |-> busy_o);
  a_r4_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sample_o) |-> $past(en));
  a_r12_flag_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    res_load |=> irq_flag_o);
  a_r11_format_zeros: assert property (@(posedge clk) disable iff (!rst_n)
    res_load |=> ($past(cfg_fmt) ? (result_o[5:0] == 6'd0) : (result_o[15:10] == 6'd0)));
  a_r2_locked_b: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr_en && wr_sel) |=> $stable(ctrl_b_q));
  a_r6_single_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (res_load && cfg_mode == 2'd0) |=> !busy_o);
  a_r10_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (convert_o && conv_done_i && !en) |=> !busy_o);
  a_r8_repeat_chan_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (res_load && cfg_mode == 2'd2) |=> (chan_o == $past(chan_o)));
endmodule

bind adc_seq_ctrl adc_seq_checks u_chk (
  .clk(clk), .rst_n(rst_n), .sample_o(sample_o), .convert_o(convert_o),
  .busy_o(busy_o), .irq_flag_o(irq_flag_o), .result_o(result_o),
  .res_load(res_load), .en(en), .cfg_fmt(cfg.fmt), .cfg_mode(cfg.mode),
  .conv_done_i(conv_done_i), .wr_en(wr_en), .wr_sel(wr_sel),
  .ctrl_b_q(ctrl_b_q), .chan_o(chan_o)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CONV_LAT   = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] ctrl_a_q, ctrl_b_q;
  logic [2:0]  timer_trig = 3'b000;
  logic        irq_ack = 1'b0;
  logic        sample_o, convert_o, busy_o, irq_flag_o, irq_o;
  logic [3:0]  chan_o;
  logic        conv_done_i;
  logic [9:0]  conv_data_i;
  logic [15:0] result_o;

  int n_chk = 0, n_bad = 0;
  int nres = 0, last_w = 0;
  int chans[256];
  logic cur_fmt = 1'b0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_ctrl i_adc_seq_ctrl (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] wa(input bit st, input bit en, input bit fl, input bit ie,
                                     input int sht, input bit msc);
    return {6'b0, 3'b101, msc, 2'(sht), ie, fl, en, st};
  endfunction

  function automatic logic [15:0] wb(input int mode, input bit fmt, input bit inv,
                                     input int src, input int div, input int ch);
    return {3'b0, 4'(ch), 3'(div), 2'(src), inv, fmt, 2'(mode)};
  endfunction

  function automatic logic [15:0] exp_word(input logic [9:0] d, input logic f);
    if (f) return {~d[9], d[8:0], 6'b0};
    return {6'b0, d};
  endfunction

  // analog model and result monitor
  initial begin
    int scnt = 0, lat = 0;
    bit pend = 0;
    logic [15:0] expv = '0;
    conv_done_i = 1'b0;
    conv_data_i = '0;
    forever begin
      @(negedge clk);
      if (sample_o) scnt++;
      else if (scnt != 0) begin last_w = scnt; scnt = 0; end
      if (conv_done_i) begin
        conv_done_i = 1'b0;
        chk("R11 result word", result_o, expv);
        chk("R12 flag after load", irq_flag_o, 1);
        nres++;
      end else if (convert_o && !pend) begin
        pend = 1; lat = 0;
      end
      if (pend) begin
        lat++;
        if (lat == CONV_LAT) begin
          conv_data_i = 10'((int'(chan_o) * 93 + nres * 7 + 11) % 1024);
          expv = exp_word(conv_data_i, cur_fmt);
          if (nres < 256) chans[nres] = chan_o;
          conv_done_i = 1'b1;
          pend = 0;
        end
      end
    end
  end

  task automatic wr(input bit sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    repeat (2) @(negedge clk);
    while (busy_o && n < 5000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_res(input int target);
    int n = 0;
    while (nres < target && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int base, lens[4];
    logic [15:0] snap;
    lens = '{4, 8, 16, 64};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ctrl_a", ctrl_a_q, 0);
    chk("R1 ctrl_b", ctrl_b_q, 0);
    chk("R1 result", result_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 flag", irq_flag_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 sample/convert", {sample_o, convert_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 window length sweep, R6 single conversion, R5 start with enable
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 8; d++) begin
        base = nres;
        wr(1'b1, wb(0, 0, 0, 0, d, d));
        wr(1'b0, wa(1, 1, 0, 0, s, 0));
        chk("R5 start reads 0", ctrl_a_q[0], 0);
        wait_idle();
        chk("R3 sample width", last_w, lens[s] * (d + 1));
        chk("R6 one result", nres - base, 1);
        chk("R6 channel", chans[base], d);
        wr(1'b0, wa(0, 0, 1, 0, s, 0));
      end
    end

    // R11 two's complement format
    cur_fmt = 1'b1;
    foreach (lens[k]) begin
      base = nres;
      wr(1'b1, wb(0, 1, 0, 0, 0, k * 5));
      wr(1'b0, wa(1, 1, 0, 0, 0, 0));
      wait_idle();
      chk("R11 tc conversion count", nres - base, 1);
      wr(1'b0, wa(0, 0, 1, 0, 0, 0));
    end
    cur_fmt = 1'b0;

    // R12 flag and interrupt
    wr(1'b1, wb(0, 0, 0, 0, 0, 1));
    wr(1'b0, wa(1, 1, 0, 1, 0, 0));
    wait_idle();
    chk("R12 irq with ie", irq_o, 1);
    @(negedge clk); irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    chk("R12 ack clears", irq_flag_o, 0);
    wr(1'b0, wa(1, 1, 0, 1, 0, 0));
    wait_idle();
    chk("R12 flag set again", irq_flag_o, 1);
    wr(1'b0, wa(0, 1, 0, 1, 0, 0));
    chk("R12 write 0 clears", irq_flag_o, 0);

    // R2 lock while enabled
    snap = ctrl_b_q;
    wr(1'b1, wb(3, 1, 1, 3, 7, 15));
    chk("R2 word B locked", ctrl_b_q, snap);
    wr(1'b0, wa(0, 1, 0, 1, 3, 1));
    chk("R2 word A hold field locked", ctrl_a_q[6:4], 3'b000);
    chk("R2 ie still writable", ctrl_a_q[3], 1);
    wr(1'b0, wa(0, 0, 0, 0, 0, 0));

    // R7 sequence with chaining
    base = nres;
    wr(1'b1, wb(1, 0, 0, 0, 0, 3));
    wr(1'b0, wa(1, 1, 0, 0, 0, 1));
    wait_idle();
    chk("R7 count", nres - base, 4);
    for (int i = 0; i < 4; i++) chk("R7 order", chans[base + i], 3 - i);
    wr(1'b0, wa(0, 0, 0, 0, 0, 0));

    // R9 sequence without chaining
    base = nres;
    wr(1'b1, wb(1, 0, 0, 0, 1, 2));
    wr(1'b0, wa(1, 1, 0, 0, 0, 0));
    wait_res(base + 1);
    repeat (30) @(negedge clk);
    chk("R9 waits for edge", nres - base, 1);
    chk("R9 busy while waiting", busy_o, 1);
    chk("R13 busy between", busy_o, 1);
    wr(1'b0, wa(1, 1, 0, 0, 0, 0));
    wait_res(base + 2);
    wr(1'b0, wa(1, 1, 0, 0, 0, 0));
    wait_idle();
    chk("R9 three results", nres - base, 3);
    for (int i = 0; i < 3; i++) chk("R9 order", chans[base + i], 2 - i);
    chk("R13 idle after last", busy_o, 0);
    wr(1'b0, wa(0, 0, 0, 0, 0, 0));

    // R8 repeat single, R10 stop on disable
    base = nres;
    wr(1'b1, wb(2, 0, 0, 0, 0, 5));
    wr(1'b0, wa(1, 1, 0, 0, 0, 1));
    wait_res(base + 3);
    wr(1'b0, wa(0, 0, 0, 0, 0, 1));
    wait_idle();
    chk("R10 idle after disable", busy_o, 0);
    snap = 16'(nres);
    repeat (60) @(negedge clk);
    chk("R10 no more conversions", nres, int'(snap));
    for (int i = base; i < nres; i++) chk("R8 repeat channel", chans[i], 5);

    // R8 repeat sequence wrap
    base = nres;
    wr(1'b1, wb(3, 0, 0, 0, 0, 2));
    wr(1'b0, wa(1, 1, 0, 0, 0, 1));
    wait_res(base + 7);
    wr(1'b0, wa(0, 0, 0, 0, 0, 1));
    wait_idle();
    for (int i = 0; i < 7; i++) chk("R8 wrap order", chans[base + i], 2 - (i % 3));

    // R4 timer source with inversion
    timer_trig = 3'b111;
    wr(1'b1, wb(0, 0, 1, 2, 0, 6));
    base = nres;
    @(negedge clk); timer_trig[1] = 1'b0; repeat (3) @(negedge clk); timer_trig[1] = 1'b1;
    repeat (40) @(negedge clk);
    chk("R4 ignored while disabled", nres - base, 0);
    wr(1'b0, wa(0, 1, 0, 0, 0, 0));
    @(negedge clk); timer_trig[0] = 1'b0; repeat (3) @(negedge clk); timer_trig[0] = 1'b1;
    repeat (40) @(negedge clk);
    chk("R4 unselected line ignored", nres - base, 0);
    @(negedge clk); timer_trig[1] = 1'b0;
    wait_idle();
    chk("R4 inverted edge starts", nres - base, 1);
    chk("R4 channel", chans[base], 6);
    timer_trig[1] = 1'b1;
    repeat (40) @(negedge clk);
    chk("R4 opposite edge ignored", nres - base, 1);
    wr(1'b0, wa(0, 0, 0, 0, 0, 0));

    // R5 start without enable
    wr(1'b1, wb(0, 0, 0, 0, 0, 4));
    base = nres;
    wr(1'b0, wa(1, 0, 0, 0, 0, 0));
    repeat (40) @(negedge clk);
    chk("R5 start without enable ignored", nres - base, 0);
    chk("R5 not busy", busy_o, 0);

    finish_run();
  end
endmodule